// File: doc/BRIEF.md
# Remote Terminal Host Memory Word Mover

This block sits between the message-handling core of a dual-redundant serial-bus remote terminal and the host's memory. It moves each data word of a message between the core and host RAM. Every word takes three phases. The block raises a request, waits for the host to grant, then acknowledges with a one-cycle strobe. During that cycle the host memory sees a complete address, a read/write line and, for writes, the data.

The RAM address has two parts. The upper part comes from the command word the core loaded at the start of the message: its transmit/receive bit and its subaddress field. The lower part is a word counter that starts at zero with each command and steps after every word. A host that does not grant in time trips a handshake-failure output. That failure also aborts the message. A received block that ends clean and holds exactly the commanded number of words produces a one-cycle good-block pulse.

The core drives `cmdLoad` with the low command bits when it accepts a command. It pulses `xferReq` once per data word and waits for `xferDone`. At the end of the message it pulses `msgEnd`, with `msgValid` reporting whether the core's own checks passed.

Top module: `rt_host_dma`

## Requirements
- R1: `hostAck` is high only in the cycle right after a cycle in which `hostReq` and `hostGrant` were both high. `hostReq` rises in the cycle after an accepted `xferReq`.
- R2: If `hostReq` has been high for TIMEOUT cycles and `hostGrant` is still low in the last of them, `hsFailN` goes low and `hostReq` drops in the next cycle. A grant in that last cycle still completes the word.
- R3: Once `hsFailN` is low, it stays low until the next `cmdLoad`. While it is low, `xferReq` raises no request and `goodBlock` stays low.
- R4: `hostAddr` is {`cmdField[10]` (transmit/receive bit, 1 = transmit), `cmdField[9:5]` (subaddress), word index[4:0]}, taken from the last `cmdLoad`.
- R5: `cmdLoad` clears the word index to zero. Each acknowledged word increments it by one, wrapping modulo 32.
- R6: `hostRead` equals the latched transmit/receive bit. For a read, `xferRdData` holds the `hostDataIn` value present during the acknowledge cycle, and `xferDone` pulses for one cycle after that acknowledge cycle. `hostStrobe` is high exactly in acknowledge cycles.
- R7: `hostDataOe` is high only in an acknowledge cycle of a write (`hostRead` low) while `bufEn` is high. In that cycle `hostDataOut` carries the `xferWrData` that came with the request.
- R8: In the cycle after `msgEnd`, `goodBlock` pulses for one cycle only if all of the following hold: the message is active, it is a receive, `msgValid` is high, and the number of acknowledged words equals the commanded count.
- R9: A word count field (`cmdField[4:0]`) of zero means 32 words.
- R10: `xferReq` is ignored when no message is active (before any `cmdLoad`, or after `msgEnd`).
- R11: After reset `hostReq`, `hostAck`, `hostStrobe`, `hostDataOe`, `xferDone` and `goodBlock` are low, and `hsFailN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdLoad | input | 1 | Core accepted a new command; latch `cmdField` |
| cmdField | input | 11 | Low command bits: T/R, subaddress, word count |
| xferReq | input | 1 | Core asks for one word to be moved |
| xferWrData | input | 16 | Word to write to host memory (receive messages) |
| xferDone | output | 1 | One-cycle pulse after a word is acknowledged |
| xferRdData | output | 16 | Word read from host memory (transmit messages) |
| msgEnd | input | 1 | Core finished the message |
| msgValid | input | 1 | Core's validation result, sampled with `msgEnd` |
| hostReq | output | 1 | Transfer request to host |
| hostGrant | input | 1 | Host grants the bus |
| hostAck | output | 1 | Acknowledge; word moves in this cycle |
| hostStrobe | output | 1 | Memory data strobe |
| hostRead | output | 1 | 1 = memory read, 0 = memory write |
| hostAddr | output | 11 | Memory address |
| hostDataIn | input | 16 | Data from host memory |
| hostDataOut | output | 16 | Data toward host memory |
| hostDataOe | output | 1 | Tri-state buffer drive enable for `hostDataOut` |
| bufEn | input | 1 | Host permission to drive the data buffers |
| hsFailN | output | 1 | Active-low handshake failure |
| goodBlock | output | 1 | One-cycle pulse: good received block |

## Verification
Some rules are checked by the bound assertions on every cycle:
- an acknowledge is always preceded by a granted request;
- a request never outlives the grant window;
- a failure keeps the request and the good-block pulse quiet;
- the buffer drive appears only on permitted write acknowledges;
- every acknowledge advances the address by exactly one.

Other behaviour only the bench's scenarios can show:
- that the data written and read match the right memory words;
- that a zero count field means 32 words;
- that a short count or a failed check withholds the good-block pulse;
- that a grant in the very last allowed cycle still succeeds;
- that requests made outside a message are dropped.

// File: rtl/rt_host_dma_pkg.sv
package rt_host_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_FAIL = 2'd3
  } dmaState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadCmd;    // latch command fields, clear counters
    logic latchWr;    // capture outgoing write word
    logic captureRd;  // capture word read from host memory
    logic advance;    // one word completed
  } dmaStrobe_t;

endpackage

// File: rtl/rt_host_dma_path.sv
module rt_host_dma_path #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  parameter int SUB_W  = 5,
  localparam int CMD_W  = CNT_W + SUB_W + 1,
  localparam int ADDR_W = CMD_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rt_host_dma_pkg::dmaStrobe_t strb,
  input  logic [CMD_W-1:0]            cmdField,
  input  logic [DATA_W-1:0]           xferWrData,
  input  logic [DATA_W-1:0]           hostDataIn,
  output logic [ADDR_W-1:0]           hostAddr,
  output logic                        hostRead,
  output logic [DATA_W-1:0]           hostDataOut,
  output logic [DATA_W-1:0]           xferRdData,
  output logic                        countMet
);

  localparam int DIR_BIT = CNT_W + SUB_W;
  localparam logic [CNT_W:0] FULL_BLOCK = (CNT_W + 1)'(1 << CNT_W);
  localparam logic [CNT_W:0] DONE_MAX   = '1;

  logic             cmdDir;
  logic [SUB_W-1:0] cmdSub;
  logic [CNT_W:0]   wcExp;
  logic [CNT_W-1:0] wordIdx;
  logic [CNT_W:0]   wordsDone;
  logic [CNT_W:0]   wcDecoded;
  logic [DATA_W-1:0] wrReg;
  logic [DATA_W-1:0] rdReg;

  // A zero count field stands for a full block.
  always_comb begin
    if (cmdField[CNT_W-1:0] == '0) wcDecoded = FULL_BLOCK;
    else                           wcDecoded = {1'b0, cmdField[CNT_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdDir    <= 1'b0;
      cmdSub    <= '0;
      wcExp     <= '0;
      wordIdx   <= '0;
      wordsDone <= '0;
    end else if (strb.loadCmd) begin
      cmdDir    <= cmdField[DIR_BIT];
      cmdSub    <= cmdField[DIR_BIT-1:CNT_W];
      wcExp     <= wcDecoded;
      wordIdx   <= '0;
      wordsDone <= '0;
    end else if (strb.advance) begin
      wordIdx <= wordIdx + 1'b1;
      if (wordsDone != DONE_MAX) wordsDone <= wordsDone + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrReg <= '0;
      rdReg <= '0;
    end else begin
      if (strb.latchWr)   wrReg <= xferWrData;
      if (strb.captureRd) rdReg <= hostDataIn;
    end
  end

  assign hostAddr    = {cmdDir, cmdSub, wordIdx};
  assign hostRead    = cmdDir;
  assign hostDataOut = wrReg;
  assign xferRdData  = rdReg;
  assign countMet    = (wordsDone == wcExp);

endmodule

// File: rtl/rt_host_dma_ctrl.sv
module rt_host_dma_ctrl #(
  parameter int TIMEOUT = 64,
  localparam int TMR_W = $clog2(TIMEOUT + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdLoad,
  input  logic                        xferReq,
  input  logic                        msgEnd,
  input  logic                        msgValid,
  input  logic                        hostGrant,
  input  logic                        bufEn,
  input  logic                        isRead,
  input  logic                        countMet,
  output rt_host_dma_pkg::dmaStrobe_t strb,
  output logic                        hostReq,
  output logic                        hostAck,
  output logic                        hostStrobe,
  output logic                        hostDataOe,
  output logic                        xferDone,
  output logic                        hsFailN,
  output logic                        goodBlock
);
  import rt_host_dma_pkg::*;

  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  dmaState_t        state;
  logic [TMR_W-1:0] timer;
  logic             msgActive;
  logic             doneQ;
  logic             gbrQ;
  logic             startWord;

  assign startWord = (state == ST_IDLE) && xferReq && msgActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      msgActive <= 1'b0;
    end else if (cmdLoad) begin
      state     <= ST_IDLE;
      timer     <= '0;
      msgActive <= 1'b1;
    end else begin
      if (msgEnd) msgActive <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startWord) begin
            state <= ST_REQ;
            timer <= '0;
          end
        end
        ST_REQ: begin
          if (hostGrant) begin
            state <= ST_ACK;
          end else if (timer == TMR_LAST) begin
            state     <= ST_FAIL;
            msgActive <= 1'b0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_ACK:  state <= ST_IDLE;
        ST_FAIL: state <= ST_FAIL;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      gbrQ  <= 1'b0;
    end else begin
      doneQ <= (state == ST_ACK) && !cmdLoad;
      gbrQ  <= msgEnd && msgValid && msgActive && !cmdLoad &&
               (state == ST_IDLE) && !isRead && countMet;
    end
  end

  always_comb begin
    strb           = '0;
    strb.loadCmd   = cmdLoad;
    strb.latchWr   = startWord && !cmdLoad;
    strb.captureRd = (state == ST_ACK) && isRead && !cmdLoad;
    strb.advance   = (state == ST_ACK) && !cmdLoad;
  end

  assign hostReq    = (state == ST_REQ);
  assign hostAck    = (state == ST_ACK);
  assign hostStrobe = (state == ST_ACK);
  assign hostDataOe = (state == ST_ACK) && !isRead && bufEn;
  assign hsFailN    = (state != ST_FAIL);
  assign xferDone   = doneQ;
  assign goodBlock  = gbrQ;

endmodule

// File: rtl/rt_host_dma.sv
module rt_host_dma #(
  parameter int TIMEOUT = 64,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 5,
  parameter int SUB_W   = 5,
  localparam int CMD_W  = CNT_W + SUB_W + 1,
  localparam int ADDR_W = CMD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLoad,
  input  logic [CMD_W-1:0]  cmdField,
  input  logic              xferReq,
  input  logic [DATA_W-1:0] xferWrData,
  output logic              xferDone,
  output logic [DATA_W-1:0] xferRdData,
  input  logic              msgEnd,
  input  logic              msgValid,
  output logic              hostReq,
  input  logic              hostGrant,
  output logic              hostAck,
  output logic              hostStrobe,
  output logic              hostRead,
  output logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  input  logic              bufEn,
  output logic              hsFailN,
  output logic              goodBlock
);

  rt_host_dma_pkg::dmaStrobe_t strb;
  logic countMet;

  rt_host_dma_ctrl #(.TIMEOUT(TIMEOUT)) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .cmdLoad   (cmdLoad),
    .xferReq   (xferReq),
    .msgEnd    (msgEnd),
    .msgValid  (msgValid),
    .hostGrant (hostGrant),
    .bufEn     (bufEn),
    .isRead    (hostRead),
    .countMet  (countMet),
    .strb      (strb),
    .hostReq   (hostReq),
    .hostAck   (hostAck),
    .hostStrobe(hostStrobe),
    .hostDataOe(hostDataOe),
    .xferDone  (xferDone),
    .hsFailN   (hsFailN),
    .goodBlock (goodBlock)
  );

  rt_host_dma_path #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SUB_W(SUB_W)) pathInst (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmdField   (cmdField),
    .xferWrData (xferWrData),
    .hostDataIn (hostDataIn),
    .hostAddr   (hostAddr),
    .hostRead   (hostRead),
    .hostDataOut(hostDataOut),
    .xferRdData (xferRdData),
    .countMet   (countMet)
  );

endmodule

// File: rtl/rt_host_dma_chk.sv
module rt_host_dma_chk #(
  parameter int TIMEOUT = 64,
  parameter int CNT_W   = 5,
  parameter int ADDR_W  = 11,
  localparam int WAIT_W = $clog2(TIMEOUT + 1) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdLoad,
  input logic              msgEnd,
  input logic              msgValid,
  input logic              hostReq,
  input logic              hostGrant,
  input logic              hostAck,
  input logic              hostRead,
  input logic              hostDataOe,
  input logic              bufEn,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hsFailN,
  input logic              goodBlock,
  input logic              xferDone
);

  // Number of consecutive earlier cycles with the request high.
  logic [WAIT_W-1:0] waitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        waitCnt <= '0;
    else if (hostReq) waitCnt <= waitCnt + 1'b1;
    else              waitCnt <= '0;
  end

  assert_ack_after_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> $past(hostReq && hostGrant));

  assert_req_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    hostReq |-> (waitCnt < WAIT_W'(TIMEOUT)));

  assert_req_timeout_fail_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostGrant && (waitCnt == WAIT_W'(TIMEOUT - 1)) && !cmdLoad) |=> !hsFailN);

  assert_fail_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !hsFailN |-> (!hostReq && !hostAck && !goodBlock));

  assert_index_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostAck && !cmdLoad) |=> (hostAddr[CNT_W-1:0] == $past(hostAddr[CNT_W-1:0]) + 1'b1));

  assert_done_follows_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostAck && !cmdLoad) |=> xferDone);

  assert_drive_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> (hostAck && !hostRead && bufEn));

  assert_gbr_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    goodBlock |-> $past(msgEnd && msgValid && !hostRead));

  assert_gbr_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    goodBlock |=> !goodBlock);

endmodule

bind rt_host_dma rt_host_dma_chk #(
  .TIMEOUT(TIMEOUT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .cmdLoad   (cmdLoad),
  .msgEnd    (msgEnd),
  .msgValid  (msgValid),
  .hostReq   (hostReq),
  .hostGrant (hostGrant),
  .hostAck   (hostAck),
  .hostRead  (hostRead),
  .hostDataOe(hostDataOe),
  .bufEn     (bufEn),
  .hostAddr  (hostAddr),
  .hsFailN   (hsFailN),
  .goodBlock (goodBlock),
  .xferDone  (xferDone)
);

// File: tb/rt_host_dma_test.sv
`timescale 1ns/1ps
module rt_host_dma_test;

  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdLoad = 1'b0;
  logic [10:0] cmdField = '0;
  logic        xferReq = 1'b0;
  logic [15:0] xferWrData = '0;
  logic        xferDone;
  logic [15:0] xferRdData;
  logic        msgEnd = 1'b0;
  logic        msgValid = 1'b0;
  logic        hostReq;
  logic        hostGrant = 1'b0;
  logic        hostAck;
  logic        hostStrobe;
  logic        hostRead;
  logic [10:0] hostAddr;
  logic [15:0] hostDataIn;
  logic [15:0] hostDataOut;
  logic        hostDataOe;
  logic        bufEn = 1'b1;
  logic        hsFailN;
  logic        goodBlock;

  int nChecks = 0;
  int nFails  = 0;
  int grantDelay = 1;
  bit grantOff = 1'b0;
  int waitN = 0;
  int cycles = 0;

  logic [15:0] hostMem [0:2047];
  logic [26:0] wrExpQ [$];   // {addr, data}
  logic [15:0] rdExpQ [$];

  always #4 clk = ~clk;

  rt_host_dma #(.TIMEOUT(TMO)) uut (
    .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .cmdField(cmdField),
    .xferReq(xferReq), .xferWrData(xferWrData), .xferDone(xferDone),
    .xferRdData(xferRdData), .msgEnd(msgEnd), .msgValid(msgValid),
    .hostReq(hostReq), .hostGrant(hostGrant), .hostAck(hostAck),
    .hostStrobe(hostStrobe), .hostRead(hostRead), .hostAddr(hostAddr),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .bufEn(bufEn), .hsFailN(hsFailN), .goodBlock(goodBlock)
  );

  assign hostDataIn = hostMem[hostAddr];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Host memory model: grants after a delay, stores driven writes.
  always @(negedge clk) begin
    if (hostDataOe) hostMem[hostAddr] = hostDataOut;
    if (hostReq && !grantOff) begin
      waitN++;
      hostGrant = (waitN >= grantDelay);
    end else begin
      waitN = 0;
      hostGrant = 1'b0;
    end
  end

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN) begin
      if (hostAck) check(hostStrobe, "R6 strobe with ack", hostStrobe, 1);
      if (hostDataOe) begin
        if (wrExpQ.size() == 0) check(1'b0, "R7 unexpected drive", {5'd0, hostAddr, hostDataOut}, 0);
        else begin
          logic [26:0] e;
          e = wrExpQ.pop_front();
          check({hostAddr, hostDataOut} == e, "R4/R7 write addr+data",
                {5'd0, hostAddr, hostDataOut}, {5'd0, e});
        end
      end
      if (xferDone && hostRead) begin
        if (rdExpQ.size() == 0) check(1'b0, "R6 unexpected read done", xferRdData, 0);
        else begin
          logic [15:0] r;
          r = rdExpQ.pop_front();
          check(xferRdData == r, "R6 read data", xferRdData, r);
        end
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic startCmd(input bit dir, input logic [4:0] sub, input logic [4:0] wc);
    @(negedge clk);
    cmdLoad = 1'b1; cmdField = {dir, sub, wc};
    @(negedge clk);
    cmdLoad = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    for (int i = 0; i < 4 * TMO + 10; i++) begin
      @(negedge clk);
      if (xferDone) return;
    end
    check(1'b0, tag, 0, 1);
  endtask

  task automatic writeWord(input logic [15:0] d, input logic [10:0] a, input bit expectDrive);
    xferReq = 1'b1; xferWrData = d;
    if (expectDrive) wrExpQ.push_back({a, d});
    @(negedge clk);
    xferReq = 1'b0;
    waitDone("R1 write completes");
  endtask

  task automatic readWord(input logic [15:0] d);
    rdExpQ.push_back(d);
    xferReq = 1'b1;
    @(negedge clk);
    xferReq = 1'b0;
    waitDone("R1 read completes");
  endtask

  task automatic endMsg(input bit valid, input bit expGbr, input string tag);
    msgEnd = 1'b1; msgValid = valid;
    @(negedge clk);
    msgEnd = 1'b0; msgValid = 1'b0;
    check(goodBlock == expGbr, tag, goodBlock, expGbr);
    @(negedge clk);
    check(goodBlock == 1'b0, "R8 single pulse", goodBlock, 0);
  endtask

  initial begin
    bit sawReq;
    for (int i = 0; i < 2048; i++) hostMem[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!hostReq && !hostAck && !hostStrobe && !hostDataOe && !xferDone && !goodBlock,
          "R11 reset outputs low", {hostReq, hostAck, hostDataOe, goodBlock}, 0);
    check(hsFailN == 1'b1, "R11 reset fail high", hsFailN, 1);
    rstN = 1'b1;
    @(negedge clk);

    // R10: no message active yet
    sawReq = 1'b0;
    xferReq = 1'b1; @(negedge clk); xferReq = 1'b0;
    repeat (3) begin if (hostReq) sawReq = 1'b1; @(negedge clk); end
    check(!sawReq, "R10 request before command ignored", sawReq, 0);

    // Receive, subaddress 5, four words; R4 R5 R7 R8
    grantDelay = 3;
    startCmd(1'b0, 5'd5, 5'd4);
    check(hostRead == 1'b0, "R6 receive drives write", hostRead, 0);
    check(hostAddr == {1'b0, 5'd5, 5'd0}, "R5 index cleared on load", hostAddr, {1'b0, 5'd5, 5'd0});
    for (int i = 0; i < 4; i++) writeWord(16'h1230 + 16'(i), {1'b0, 5'd5, 5'(i)}, 1'b1);
    endMsg(1'b1, 1'b1, "R8 good block after full receive");

    // R10: request after msgEnd ignored
    sawReq = 1'b0;
    xferReq = 1'b1; @(negedge clk); xferReq = 1'b0;
    repeat (3) begin if (hostReq) sawReq = 1'b1; @(negedge clk); end
    check(!sawReq, "R10 request after end ignored", sawReq, 0);

    // R7: buffer enable low blocks drive; index still advances (R5)
    grantDelay = 1;
    startCmd(1'b0, 5'd9, 5'd2);
    bufEn = 1'b0;
    writeWord(16'hDEAD, {1'b0, 5'd9, 5'd0}, 1'b0);
    bufEn = 1'b1;
    check(hostMem[{1'b0, 5'd9, 5'd0}] == 16'h0, "R7 no write without buffer enable",
          hostMem[{1'b0, 5'd9, 5'd0}], 0);
    check(hostAddr[4:0] == 5'd1, "R5 index advanced", hostAddr[4:0], 1);
    writeWord(16'hBEEF, {1'b0, 5'd9, 5'd1}, 1'b1);
    endMsg(1'b0, 1'b0, "R8 no good block when invalid");

    // Short receive: wrong count
    startCmd(1'b0, 5'd2, 5'd4);
    for (int i = 0; i < 3; i++) writeWord(16'h5500 + 16'(i), {1'b0, 5'd2, 5'(i)}, 1'b1);
    endMsg(1'b1, 1'b0, "R8 no good block on short count");

    // Transmit, subaddress 3; R6 R4 R8
    for (int i = 0; i < 3; i++) hostMem[{1'b1, 5'd3, 5'(i)}] = 16'hA000 + 16'(i * 7);
    grantDelay = 2;
    startCmd(1'b1, 5'd3, 5'd3);
    check(hostRead == 1'b1, "R6 transmit drives read", hostRead, 1);
    for (int i = 0; i < 3; i++) readWord(16'hA000 + 16'(i * 7));
    check(hostMem[{1'b1, 5'd3, 5'd0}] == 16'hA000, "R7 read leaves memory", hostMem[{1'b1, 5'd3, 5'd0}], 16'hA000);
    endMsg(1'b1, 1'b0, "R8 no good block for transmit");

    // Zero count field = 32 words, index wraps; R9 R5
    grantDelay = 1;
    startCmd(1'b0, 5'd17, 5'd0);
    for (int i = 0; i < 31; i++) writeWord(16'h7000 + 16'(i), {1'b0, 5'd17, 5'(i)}, 1'b1);
    endMsg(1'b1, 1'b0, "R9 31 words are short of 32");
    startCmd(1'b0, 5'd17, 5'd0);
    for (int i = 0; i < 32; i++) writeWord(16'h7100 + 16'(i), {1'b0, 5'd17, 5'(i)}, 1'b1);
    check(hostAddr[4:0] == 5'd0, "R5 index wraps after 32", hostAddr[4:0], 0);
    endMsg(1'b1, 1'b1, "R9 zero field completes at 32");

    // Grant in last allowed cycle succeeds; R2 boundary
    grantDelay = TMO;
    startCmd(1'b0, 5'd1, 5'd1);
    writeWord(16'h4242, {1'b0, 5'd1, 5'd0}, 1'b1);
    check(hsFailN == 1'b1, "R2 grant at last cycle no fail", hsFailN, 1);
    endMsg(1'b1, 1'b1, "R8 good block after late grant");

    // Timeout; R2 R3
    grantOff = 1'b1;
    startCmd(1'b0, 5'd4, 5'd1);
    xferReq = 1'b1; xferWrData = 16'h9999; @(negedge clk); xferReq = 1'b0;
    repeat (TMO - 1) @(negedge clk);
    check(hostReq == 1'b1 && hsFailN == 1'b1, "R2 still waiting in window", {hostReq, hsFailN}, 2'b11);
    @(negedge clk);
    check(hsFailN == 1'b0, "R2 fail after timeout", hsFailN, 0);
    check(hostReq == 1'b0, "R2 request dropped", hostReq, 0);
    grantOff = 1'b0;
    sawReq = 1'b0;
    xferReq = 1'b1; @(negedge clk); xferReq = 1'b0;
    repeat (3) begin if (hostReq) sawReq = 1'b1; @(negedge clk); end
    check(!sawReq, "R3 request ignored after fail", sawReq, 0);
    check(hsFailN == 1'b0, "R3 fail held", hsFailN, 0);
    endMsg(1'b1, 1'b0, "R3 no good block after fail");
    startCmd(1'b0, 5'd4, 5'd1);
    check(hsFailN == 1'b1, "R3 fail cleared by new command", hsFailN, 1);
    writeWord(16'h0F0F, {1'b0, 5'd4, 5'd0}, 1'b1);
    endMsg(1'b1, 1'b1, "R8 good block after recovery");

    repeat (3) @(negedge clk);
    check(wrExpQ.size() == 0, "R7 all writes seen", wrExpQ.size(), 0);
    check(rdExpQ.size() == 0, "R6 all reads seen", rdExpQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule